// File: doc/BRIEF.md
# Stereo dB-Stepped Attenuator with Soft Mute

This block scales a stream of 24-bit signed stereo samples by a gain set in half-decibel steps. Each channel has an 8-bit attenuation code, where code 0 is unity gain, every increment removes another 0.5 dB, and the all-ones code silences the channel outright. A shared-setting mode lets the left code drive both channels. The code is added to a two-bit power-limit setting (0, 1.5, 3 or 4.5 dB of extra cut) and to an externally supplied foldback attenuation, so that one combined figure sets the gain.

The combined figure is never applied at once. A per-channel ramp register moves by at most one half-decibel step per sample toward its target, so that mute, unmute and volume changes all fade. A soft-mute request forces the target to full mute. The ramp starts at full mute after reset, so the output stays silent and fades in only once the request is released. A status output reports that both channels sit at full mute.

The gain is built from a twelve-entry table covering one 6 dB span, followed by an arithmetic right shift for each whole 6 dB. Samples are taken on a one-cycle valid strobe and leave one clock later with their own valid strobe.

Top module: `stereo_db_atten`

## Requirements
- R1: Each channel's target attenuation, in 0.5 dB units, is its volume code plus the power-limit steps plus the foldback input; when the volume code is 255 or this sum is 255 or more, the target is 255 (mute).
- R2: For an applied attenuation a below 255, with q = a / 12 and r = a mod 12, the output is floor(x * M[r] / 2^(15+q)), where M[r] = round(32768 * 10^(-r/40)) and x is the signed input sample.
- R3: An applied attenuation of 255 gives an output of exactly zero.
- R4: On every accepted sample the applied attenuation moves one step toward the target (or stays if equal); the sample is scaled with the attenuation in effect before that step; without a sample it does not change.
- R5: While soft-mute is requested the target is 255, so the attenuation rises one step per sample until the output is silent.
- R6: After reset both applied attenuations are 255: outputs and out_valid are 0 and smute_done is 1.
- R7: smute_done is 1 exactly when both channels' applied attenuations are 255.
- R8: With vol_shared at 1 the right channel uses vol_l and vol_r has no effect.
- R9: out_valid is 1 in the cycle after each smp_valid and 0 otherwise; out_l and out_r keep their values between samples.
- R10: plim_sel values 0, 1, 2 and 3 add 0, 3, 6 and 9 steps (0, 1.5, 3 and 4.5 dB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a stereo sample is present |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| vol_l | input | 8 | Left attenuation code, 0.5 dB per step, 255 = mute |
| vol_r | input | 8 | Right attenuation code, 0.5 dB per step, 255 = mute |
| vol_shared | input | 1 | 1: vol_l sets both channels |
| plim_sel | input | 2 | Power-limit cut: 0 / 1.5 / 3 / 4.5 dB |
| fold_att | input | 8 | Foldback attenuation, 0.5 dB per step |
| smute_req | input | 1 | Soft-mute request |
| out_valid | output | 1 | Strobe: out_l/out_r carry a new sample |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |
| smute_done | output | 1 | Both channels at full mute |

## Verification
The fade-in from reset is driven with a falling ramp of sample values, so every intermediate attenuation from 255 down to the target is met with a different input; this separates a wrong step size or step timing from a wrong gain value. Once settled, full-scale positive and negative samples, minus one and small odd values check the table and the shift together, and negative values show whether the shift rounds toward minus infinity. Different left and right codes, the shared-setting mode, each power-limit value and a foldback sum that crosses the mute code tell apart mixed-up channels and a missing or wrong term in the sum. A full soft-mute fade and its release confirm that silence is reached only after the ramp completes and that the status follows it.

// File: rtl/sda_pkg.sv
// Package: shared constants and the one-span gain table.
// Assumes gains are unsigned Q1.15 with 32768 meaning unity.
package sda_pkg;

    localparam int STEPS_PER_SPAN = 12;   // half-dB steps in 6 dB
    localparam int MANT_W         = 16;   // table entry width
    localparam int FRAC_W         = 15;   // fraction bits of a table entry
    localparam int PLIM_STEP      = 3;    // half-dB steps per power-limit level

    // Gain for r half-dB steps below unity, r in 0..11: round(32768*10^(-r/40)).
    function automatic logic [MANT_W-1:0] span_gain(input logic [3:0] r);
        case (r)
            4'd0:    span_gain = 16'd32768;
            4'd1:    span_gain = 16'd30935;
            4'd2:    span_gain = 16'd29205;
            4'd3:    span_gain = 16'd27571;
            4'd4:    span_gain = 16'd26029;
            4'd5:    span_gain = 16'd24573;
            4'd6:    span_gain = 16'd23198;
            4'd7:    span_gain = 16'd21900;
            4'd8:    span_gain = 16'd20675;
            4'd9:    span_gain = 16'd19519;
            4'd10:   span_gain = 16'd18427;
            4'd11:   span_gain = 16'd17396;
            default: span_gain = 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/sda_target.sv
// Module: sda_target
// Combines volume code, power-limit level and foldback into one target
// attenuation in half-dB units. Saturates to the mute code (all ones).
// Assumes the mute code is the top value of an AW-bit code.
module sda_target #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] vol,
    input  logic [1:0]    plim,
    input  logic [AW-1:0] fold,
    input  logic          mute_req,
    output logic [AW-1:0] target
);
    import sda_pkg::*;

    localparam int            SW     = AW + 3;
    localparam logic [SW-1:0] MUTE_S = SW'((1 << AW) - 1);

    logic [SW-1:0] plim_steps;
    logic [SW-1:0] sum;

    // Sum the three attenuation terms and clamp at the mute code.
    always_comb begin
        plim_steps = SW'(plim) * SW'(PLIM_STEP);
        sum        = SW'(vol) + plim_steps + SW'(fold);
        if (mute_req || (vol == {AW{1'b1}}) || (sum >= MUTE_S))
            target = {AW{1'b1}};
        else
            target = sum[AW-1:0];
    end

endmodule

// File: rtl/sda_ramp.sv
// Module: sda_ramp
// Holds the applied attenuation of one channel and moves it one step
// toward the target on every accepted sample. Resets to full mute.
module sda_ramp #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] att
);

    // Step the applied attenuation toward its target once per sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            att <= {AW{1'b1}};
        else if (adv) begin
            if (att < target)
                att <= att + 1'b1;
            else if (att > target)
                att <= att - 1'b1;
        end
    end

endmodule

// File: rtl/sda_scale.sv
// Module: sda_scale
// Scales one signed sample by the gain for a half-dB attenuation code:
// table lookup within a 6 dB span, then an arithmetic shift per span.
// Result is registered on load; the mute code yields zero.
module sda_scale #(
    parameter int DW = 24,
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [DW-1:0] din,
    input  logic [AW-1:0]        att,
    output logic signed [DW-1:0] dout
);
    import sda_pkg::*;

    localparam int            PW     = DW + MANT_W + 1;
    localparam logic [AW-1:0] SPAN_C = AW'(STEPS_PER_SPAN);

    logic [AW-1:0]        span;
    logic [3:0]           rem;
    logic [MANT_W-1:0]    mant;
    logic signed [PW-1:0] prod;
    logic signed [DW-1:0] scaled;

    // Split the code into whole spans and a remainder, then multiply and shift.
    always_comb begin
        span   = att / SPAN_C;
        rem    = 4'(att % SPAN_C);
        mant   = span_gain(rem);
        prod   = PW'(din) * PW'($signed({1'b0, mant}));
        scaled = DW'(prod >>> (FRAC_W + int'(span)));
    end

    // Register the scaled sample when a new one arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= (att == {AW{1'b1}}) ? '0 : scaled;
    end

endmodule

// File: rtl/stereo_db_atten.sv
// Module: stereo_db_atten (top)
// Two-channel half-dB attenuator with ramped soft mute. Each channel has
// a target builder, a ramp register and a scaler. Output is one cycle
// after the input strobe. Assumes smp_valid is a single-cycle strobe.
module stereo_db_atten #(
    parameter int DW = 24,
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    input  logic [AW-1:0]        vol_l,
    input  logic [AW-1:0]        vol_r,
    input  logic                 vol_shared,
    input  logic [1:0]           plim_sel,
    input  logic [AW-1:0]        fold_att,
    input  logic                 smute_req,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r,
    output logic                 smute_done
);

    localparam int NCH = 2;

    logic [AW-1:0]        vol_ch [NCH];
    logic signed [DW-1:0] in_ch  [NCH];
    logic signed [DW-1:0] out_ch [NCH];
    logic [AW-1:0]        tgt_ch [NCH];
    logic [AW-1:0]        att_ch [NCH];
    logic [AW-1:0]        att_l;
    logic [AW-1:0]        att_r;

    // Route per-channel volume (shared mode reuses the left code) and samples.
    always_comb begin
        vol_ch[0] = vol_l;
        vol_ch[1] = vol_shared ? vol_l : vol_r;
        in_ch[0]  = in_l;
        in_ch[1]  = in_r;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        sda_target #(.AW(AW)) u_target (
            .vol      (vol_ch[ch]),
            .plim     (plim_sel),
            .fold     (fold_att),
            .mute_req (smute_req),
            .target   (tgt_ch[ch])
        );

        sda_ramp #(.AW(AW)) u_ramp (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (smp_valid),
            .target (tgt_ch[ch]),
            .att    (att_ch[ch])
        );

        sda_scale #(.DW(DW), .AW(AW)) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (smp_valid),
            .din   (in_ch[ch]),
            .att   (att_ch[ch]),
            .dout  (out_ch[ch])
        );
    end

    // Expose channel results and the mute status.
    always_comb begin
        out_l      = out_ch[0];
        out_r      = out_ch[1];
        att_l      = att_ch[0];
        att_r      = att_ch[1];
        smute_done = (att_l == {AW{1'b1}}) && (att_r == {AW{1'b1}});
    end

    // Delay the input strobe to mark the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= smp_valid;
    end

endmodule

// File: rtl/sda_checks.sv
// Module: sda_checks
// Temporal checks on the attenuator, bound into stereo_db_atten.
module sda_checks #(
    parameter int DW = 24,
    parameter int AW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_valid,
    input logic                 smute_req,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_l,
    input logic signed [DW-1:0] out_r,
    input logic                 smute_done,
    input logic [AW-1:0]        att_l,
    input logic [AW-1:0]        att_r
);

    p_step_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ({1'b0, att_l} == {1'b0, $past(att_l)}) ||
                      ({1'b0, att_l} == {1'b0, $past(att_l)} + 1'b1) ||
                      ({1'b0, att_l} + 1'b1 == {1'b0, $past(att_l)}));

    p_step_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ({1'b0, att_r} == {1'b0, $past(att_r)}) ||
                      ({1'b0, att_r} == {1'b0, $past(att_r)} + 1'b1) ||
                      ({1'b0, att_r} + 1'b1 == {1'b0, $past(att_r)}));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(att_l) && $stable(att_r));

    p_mute_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && att_l == {AW{1'b1}}) |=> (out_l == '0));

    p_mute_zero_rch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && att_r == {AW{1'b1}}) |=> (out_r == '0));

    p_fade_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smute_req && smp_valid) |=> (att_l >= $past(att_l)) && (att_r >= $past(att_r)));

    p_done_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smute_done && smp_valid) |=> (out_l == '0) && (out_r == '0));

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);

    p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid && $stable(out_l) && $stable(out_r));

endmodule

bind stereo_db_atten sda_checks #(.DW(DW), .AW(AW)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smute_req  (smute_req),
    .out_valid  (out_valid),
    .out_l      (out_l),
    .out_r      (out_r),
    .smute_done (smute_done),
    .att_l      (att_l),
    .att_r      (att_r)
);

// File: tb/stereo_db_atten_test.sv
// Directed bench for stereo_db_atten: a reference model of the ramp and
// gain, one task per scenario, counting checks and failures.
module stereo_db_atten_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [23:0] in_l = '0;
    logic signed [23:0] in_r = '0;
    logic [7:0]         vol_l = 8'd0;
    logic [7:0]         vol_r = 8'd0;
    logic               vol_shared = 1'b0;
    logic [1:0]         plim_sel = 2'd0;
    logic [7:0]         fold_att = 8'd0;
    logic               smute_req = 1'b0;
    logic               out_valid;
    logic signed [23:0] out_l;
    logic signed [23:0] out_r;
    logic               smute_done;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  finished = 1'b0;
    int  m_att_l  = 255;
    int  m_att_r  = 255;
    longint last_l = 0;
    longint last_r = 0;

    always #5 clk = ~clk;

    stereo_db_atten uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .in_l(in_l), .in_r(in_r), .vol_l(vol_l), .vol_r(vol_r),
        .vol_shared(vol_shared), .plim_sel(plim_sel), .fold_att(fold_att),
        .smute_req(smute_req), .out_valid(out_valid), .out_l(out_l),
        .out_r(out_r), .smute_done(smute_done)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Target from R1, R5, R10.
    function automatic int tgt(input int vol, input int plim, input int fold, input bit sm);
        int s;
        if (sm || vol == 255) return 255;
        s = vol + 3 * plim + fold;
        return (s >= 255) ? 255 : s;
    endfunction

    // Gain model from R2 and R3.
    function automatic longint exp_scale(input logic signed [23:0] x, input int a);
        real    g;
        longint m;
        longint p;
        if (a >= 255) return 0;
        g = $pow(10.0, -real'(a % 12) / 40.0) * 32768.0;
        m = longint'($rtoi(g + 0.5));
        p = longint'(x) * m;
        return p >>> (15 + a / 12);
    endfunction

    function automatic int step_to(input int a, input int t);
        if (a < t) return a + 1;
        if (a > t) return a - 1;
        return a;
    endfunction

    // Send one stereo sample and check it against the model (R2, R4, R7, R9).
    task automatic send(input string tag, input logic signed [23:0] a,
                        input logic signed [23:0] b);
        int tl;
        int tr;
        longint el;
        longint er;
        tl = tgt(vol_l, plim_sel, fold_att, smute_req);
        tr = tgt(vol_shared ? vol_l : vol_r, plim_sel, fold_att, smute_req);
        el = exp_scale(a, m_att_l);
        er = exp_scale(b, m_att_r);
        in_l = a;
        in_r = b;
        smp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        m_att_l = step_to(m_att_l, tl);
        m_att_r = step_to(m_att_r, tr);
        last_l = el;
        last_r = er;
        chk({tag, " left"},  longint'(out_l), el);
        chk({tag, " right"}, longint'(out_r), er);
        chk("R9 out_valid", longint'(out_valid), 1);
        chk("R7 smute_done", longint'(smute_done),
            (m_att_l == 255 && m_att_r == 255) ? 1 : 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 out_l",      longint'(out_l), 0);
        chk("R6 out_r",      longint'(out_r), 0);
        chk("R6 out_valid",  longint'(out_valid), 0);
        chk("R6 smute_done", longint'(smute_done), 1);
    endtask

    // Fade in from reset mute with distinct samples at every step.
    task automatic t_fade_in();
        vol_l = 8'd13;
        vol_r = 8'd30;
        smute_req = 1'b0;
        send("R6 first sample silent", 24'sh400000, -24'sh400000);
        for (int i = 0; i < 250; i++)
            send("R4 fade-in", 24'sh7FF000 - 24'(i * 4099), -24'sh7FF000 + 24'(i * 3001));
    endtask

    // Settled gains with distinct data patterns.
    task automatic t_patterns();
        send("R2 full positive", 24'sh7FFFFF, 24'sh7FFFFF);
        send("R2 full negative", 24'sh800000, 24'sh800000);
        send("R2 minus one",     -24'sd1, -24'sd1);
        send("R2 small odd",     24'sd37, -24'sd37);
        send("R2 zero",          24'sd0, 24'sd12345);
    endtask

    // Outputs and valid hold between samples (R9).
    task automatic t_hold();
        send("R9 before idle", 24'sh123456, -24'sh0ABCDE);
        for (int i = 0; i < 3; i++) begin
            in_l = 24'sh5A5A5A;
            in_r = -24'sh111111;
            @(posedge clk);
            @(negedge clk);
            chk("R9 idle valid", longint'(out_valid), 0);
            chk("R9 idle hold left",  longint'(out_l), last_l);
            chk("R9 idle hold right", longint'(out_r), last_r);
        end
    endtask

    // Power-limit levels and foldback in the sum (R1, R10).
    task automatic t_limits();
        vol_l = 8'd2;
        vol_r = 8'd4;
        for (int p = 0; p < 4; p++) begin
            plim_sel = 2'(p);
            fold_att = 8'(p * 5);
            for (int i = 0; i < 40; i++)
                send("R10 power limit", 24'sh300000 + 24'(i * 77), -24'sh2F0000);
        end
        vol_l = 8'd240;
        vol_r = 8'd230;
        plim_sel = 2'd3;
        fold_att = 8'd10;
        for (int i = 0; i < 260; i++)
            send("R1 sum saturates to mute", 24'sh7FFFFF, 24'sh7FFFFF);
        plim_sel = 2'd0;
        fold_att = 8'd0;
    endtask

    // Shared-setting mode ignores vol_r (R8).
    task automatic t_shared();
        vol_shared = 1'b1;
        vol_l = 8'd18;
        vol_r = 8'd0;
        for (int i = 0; i < 260; i++) begin
            vol_r = 8'(i * 7);
            send("R8 shared volume", 24'sh654321, 24'sh654321 - 24'(i));
        end
        vol_shared = 1'b0;
    endtask

    // Top code mutes regardless of the other terms (R3).
    task automatic t_mute_code();
        vol_l = 8'd255;
        vol_r = 8'd0;
        for (int i = 0; i < 260; i++)
            send("R3 mute code", 24'sh7FFFFF, -24'sh7FFFFF);
        chk("R3 left silent", longint'(out_l), 0);
    endtask

    // Soft mute fade down and release (R5, R7).
    task automatic t_soft_mute();
        vol_l = 8'd0;
        vol_r = 8'd0;
        for (int i = 0; i < 260; i++)
            send("R5 unmute", 24'sh200000, 24'sh200000);
        smute_req = 1'b1;
        for (int i = 0; i < 256; i++)
            send("R5 fade down", 24'sh7FFFFF - 24'(i * 11), 24'sh800000 + 24'(i * 13));
        chk("R7 done after fade", longint'(smute_done), 1);
        smute_req = 1'b0;
        send("R7 release", 24'sh400000, 24'sh400000);
        chk("R7 done drops", longint'(smute_done), 0);
    endtask

    initial begin
        t_reset();
        t_fade_in();
        t_patterns();
        t_hold();
        t_limits();
        t_shared();
        t_mute_code();
        t_soft_mute();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule